// File: doc/BRIEF.md
# List Path Selection Sorter

This block does the path-selection step of a list successive-cancellation decoder for polar codes. Each of the `LIST_SIZE` surviving decoding paths offers two candidates for the current bit: one that extends the path with a 0 and one that extends it with a 1. The block gets all `2*LIST_SIZE` candidate metrics at once. The metrics are negative log-likelihoods, so a smaller value is better. The block keeps the `LIST_SIZE` best candidates. For each kept candidate it reports the parent path index, the decided bit value and the metric.

The metric vector and the active-path mask go into a pipeline register first. The selection is then made in a single cycle from that register by a full matrix of pairwise magnitude comparators, with one comparator per candidate pair. Each candidate's rank is the number of candidates that beat it. The candidates with rank below `LIST_SIZE` are placed into the output slots in rank order. The surrounding decoder spends one idle cycle on every information bit while it waits for this result. Equal metrics are resolved in favour of the lower flat candidate index. Paths that are not yet live are masked out, so at the start of decoding only the single initial path can be chosen.

Top module: `list_path_selector`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` is 0 in the following cycle.
- R2: `out_valid` is 1 in the cycle after an edge at which `in_valid` was 1, and 0 otherwise. The slot outputs in that cycle are derived from the metrics and mask sampled at that edge.
- R3: The candidate for path p and bit value b has flat index c = 2p+b, and its metric is `in_metrics[c*METRIC_W +: METRIC_W]`.
- R4: The survivors are the `LIST_SIZE` candidates with the smallest metrics. A smaller metric is better.
- R5: Output slot 0 holds the best survivor. Slot metrics do not decrease from slot 0 upward.
- R6: Among candidates with equal metrics, the one with the lower flat index ranks first and takes the lower slot.
- R7: Slot s reports the parent path in `out_parent[s*PIDX_W +: PIDX_W]` (with PIDX_W = clog2(LIST_SIZE)), the decided bit in `out_bit[s]`, and the survivor's metric in `out_metric[s*METRIC_W +: METRIC_W]`.
- R8: When `path_active[p]` is 0, both candidates of path p take the all-ones metric. A slot that names path p therefore shows the all-ones metric. With only path 0 active and its metrics below all-ones, slots 0 and 1 hold path 0's two candidates.
- R9: At an edge where `in_valid` is 0, the registered inputs are held, so every slot output keeps its value.
- R10: No candidate appears in more than one output slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Metric vector valid; loads the pipeline register |
| in_metrics | input | 2*LIST_SIZE*METRIC_W | Candidate metrics, flat index 2p+b |
| path_active | input | LIST_SIZE | One bit per path; 0 masks both candidates of that path |
| out_valid | output | 1 | Selection result valid |
| out_parent | output | LIST_SIZE*PIDX_W | Parent path index per slot |
| out_bit | output | LIST_SIZE | Decided bit value per slot |
| out_metric | output | LIST_SIZE*METRIC_W | Survivor metric per slot |

## Verification
The only state is the pipeline register, so a wrong held value shows up at the slot outputs in the same cycle it is loaded. A register that drops or mis-masks a path surfaces one cycle after the offending `in_valid` edge, as a wrong parent, bit or metric in some slot. A register that fails to hold surfaces on the first idle cycle. A broken comparator or rank count does not always show: it appears only when the affected pair decides membership or order. For that reason the stimulus includes full ties, partial ties, reversed orderings and random masks, and every cycle is compared against a behavioural selection model.

// File: rtl/lps_pkg.sv
// Shared helpers for the list path selection sorter.
// Assumes list sizes of 2 or 4, so candidate counts are powers of two.
package lps_pkg;

    // Width of an index that counts n items (at least 1 bit).
    function automatic int unsigned idx_w(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/lps_capture.sv
// Pipeline register in front of the sorter.
// Applies the active-path mask: both candidates of an inactive path are
// replaced by the all-ones metric before being stored. The register loads
// only when in_valid is high; otherwise it holds its contents.
module lps_capture #(
    parameter int unsigned LIST_SIZE = 4,
    parameter int unsigned METRIC_W  = 13,
    localparam int unsigned N_CAND   = 2 * LIST_SIZE
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [N_CAND*METRIC_W-1:0]   in_metrics,
    input  logic [LIST_SIZE-1:0]         path_active,
    output logic                         held_valid,
    output logic [N_CAND*METRIC_W-1:0]   held_metrics
);

    logic [N_CAND*METRIC_W-1:0] masked;

    // Force metrics of inactive paths to the worst value.
    for (genvar c = 0; c < N_CAND; c++) begin : g_mask
        assign masked[c*METRIC_W +: METRIC_W] =
            path_active[c/2] ? in_metrics[c*METRIC_W +: METRIC_W]
                             : {METRIC_W{1'b1}};
    end

    // Capture the masked vector on a valid cycle; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_valid   <= 1'b0;
            held_metrics <= '0;
        end else begin
            held_valid <= in_valid;
            if (in_valid) begin
                held_metrics <= masked;
            end
        end
    end

endmodule

// File: rtl/lps_rank.sv
// Pairwise comparator matrix and rank counters.
// One magnitude comparator per unordered candidate pair (i<j): i beats j
// when its metric is less than or equal to j's (ties go to the lower index).
// A candidate's rank is the number of candidates that beat it, giving a
// permutation of 0..N_CAND-1.
module lps_rank #(
    parameter int unsigned N_CAND   = 8,
    parameter int unsigned METRIC_W = 13,
    parameter int unsigned RANK_W   = 3
) (
    input  logic [N_CAND*METRIC_W-1:0] metrics,
    output logic [N_CAND*RANK_W-1:0]   ranks
);

    // beat[c*N_CAND + d] is 1 when candidate d beats candidate c.
    logic [N_CAND*N_CAND-1:0] beat;

    for (genvar i = 0; i < N_CAND; i++) begin : g_row
        for (genvar j = 0; j < N_CAND; j++) begin : g_col
            if (i == j) begin : g_diag
                assign beat[i*N_CAND + j] = 1'b0;
            end else if (i < j) begin : g_cmp
                // Shared comparator for the pair (i, j).
                logic i_wins;
                assign i_wins = metrics[i*METRIC_W +: METRIC_W]
                             <= metrics[j*METRIC_W +: METRIC_W];
                assign beat[j*N_CAND + i] = i_wins;
                assign beat[i*N_CAND + j] = ~i_wins;
            end
        end
    end

    // Count how many candidates beat each candidate.
    for (genvar c = 0; c < N_CAND; c++) begin : g_cnt
        always_comb begin
            logic [RANK_W-1:0] cnt;
            cnt = '0;
            for (int d = 0; d < N_CAND; d++) begin
                cnt = cnt + RANK_W'(beat[c*N_CAND + d]);
            end
            ranks[c*RANK_W +: RANK_W] = cnt;
        end
    end

endmodule

// File: rtl/lps_place.sv
// Places the best LIST_SIZE candidates into output slots by rank.
// Assumes ranks form a permutation, so exactly one candidate matches each
// slot; the selection is an AND-OR multiplexer over all candidates.
module lps_place #(
    parameter int unsigned LIST_SIZE = 4,
    parameter int unsigned METRIC_W  = 13,
    parameter int unsigned RANK_W    = 3,
    parameter int unsigned PIDX_W    = 2,
    localparam int unsigned N_CAND   = 2 * LIST_SIZE
) (
    input  logic [N_CAND*METRIC_W-1:0]    metrics,
    input  logic [N_CAND*RANK_W-1:0]      ranks,
    output logic [LIST_SIZE*PIDX_W-1:0]   slot_parent,
    output logic [LIST_SIZE-1:0]          slot_bit,
    output logic [LIST_SIZE*METRIC_W-1:0] slot_metric
);

    for (genvar s = 0; s < LIST_SIZE; s++) begin : g_slot
        logic [RANK_W-1:0]   cand;
        logic [METRIC_W-1:0] met;

        // Select the candidate whose rank equals this slot number.
        always_comb begin
            cand = '0;
            met  = '0;
            for (int c = 0; c < N_CAND; c++) begin
                if (ranks[c*RANK_W +: RANK_W] == RANK_W'(s)) begin
                    cand = cand | RANK_W'(c);
                    met  = met | metrics[c*METRIC_W +: METRIC_W];
                end
            end
        end

        assign slot_parent[s*PIDX_W +: PIDX_W]     = cand[RANK_W-1:1];
        assign slot_bit[s]                         = cand[0];
        assign slot_metric[s*METRIC_W +: METRIC_W] = met;
    end

endmodule

// File: rtl/list_path_selector.sv
// List path selection sorter.
// Takes 2*LIST_SIZE candidate metrics (path p, bit b at flat index 2p+b),
// registers them with the active mask applied, and in the following cycle
// presents the LIST_SIZE smallest in ascending order with parent index and
// decided bit. Assumes LIST_SIZE is 2 or 4.
module list_path_selector #(
    parameter int unsigned LIST_SIZE = 4,
    parameter int unsigned METRIC_W  = 13,
    localparam int unsigned N_CAND   = 2 * LIST_SIZE,
    localparam int unsigned PIDX_W   = lps_pkg::idx_w(LIST_SIZE),
    localparam int unsigned RANK_W   = lps_pkg::idx_w(N_CAND)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [N_CAND*METRIC_W-1:0]    in_metrics,
    input  logic [LIST_SIZE-1:0]          path_active,
    output logic                          out_valid,
    output logic [LIST_SIZE*PIDX_W-1:0]   out_parent,
    output logic [LIST_SIZE-1:0]          out_bit,
    output logic [LIST_SIZE*METRIC_W-1:0] out_metric
);

    logic                       held_valid;
    logic [N_CAND*METRIC_W-1:0] held_metrics;
    logic [N_CAND*RANK_W-1:0]   ranks;

    lps_capture #(
        .LIST_SIZE (LIST_SIZE),
        .METRIC_W  (METRIC_W)
    ) i_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_metrics   (in_metrics),
        .path_active  (path_active),
        .held_valid   (held_valid),
        .held_metrics (held_metrics)
    );

    lps_rank #(
        .N_CAND   (N_CAND),
        .METRIC_W (METRIC_W),
        .RANK_W   (RANK_W)
    ) i_rank (
        .metrics (held_metrics),
        .ranks   (ranks)
    );

    lps_place #(
        .LIST_SIZE (LIST_SIZE),
        .METRIC_W  (METRIC_W),
        .RANK_W    (RANK_W),
        .PIDX_W    (PIDX_W)
    ) i_place (
        .metrics     (held_metrics),
        .ranks       (ranks),
        .slot_parent (out_parent),
        .slot_bit    (out_bit),
        .slot_metric (out_metric)
    );

    assign out_valid = held_valid;

endmodule

// File: rtl/lps_checker.sv
// Property checker for list_path_selector, attached by bind below.
// Observes only the top-level ports.
module lps_checker #(
    parameter int unsigned LIST_SIZE = 4,
    parameter int unsigned METRIC_W  = 13,
    localparam int unsigned N_CAND   = 2 * LIST_SIZE,
    localparam int unsigned PIDX_W   = lps_pkg::idx_w(LIST_SIZE)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic [N_CAND*METRIC_W-1:0]    in_metrics,
    input logic [LIST_SIZE-1:0]          path_active,
    input logic                          out_valid,
    input logic [LIST_SIZE*PIDX_W-1:0]   out_parent,
    input logic [LIST_SIZE-1:0]          out_bit,
    input logic [LIST_SIZE*METRIC_W-1:0] out_metric
);

    logic [PIDX_W:0]     cand [LIST_SIZE];
    logic [METRIC_W-1:0] met  [LIST_SIZE];
    logic [N_CAND*METRIC_W-1:0] unused_metrics;
    assign unused_metrics = in_metrics;

    for (genvar s = 0; s < LIST_SIZE; s++) begin : g_unpack
        assign cand[s] = {out_parent[s*PIDX_W +: PIDX_W], out_bit[s]};
        assign met[s]  = out_metric[s*METRIC_W +: METRIC_W];
    end

    // R1
    reset_clears_valid_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R2
    valid_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid && rst_n));

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |->
            ($stable(out_parent) && $stable(out_bit) && $stable(out_metric)));

    for (genvar s = 0; s + 1 < LIST_SIZE; s++) begin : g_order
        // R5
        slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (met[s] <= met[s+1]));
        // R6
        tie_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && met[s] == met[s+1]) |-> (cand[s] < cand[s+1]));
    end

    for (genvar s = 0; s < LIST_SIZE; s++) begin : g_pair
        for (genvar t = s + 1; t < LIST_SIZE; t++) begin : g_other
            // R10
            distinct_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (cand[s] != cand[t]));
        end
    end

    for (genvar p = 0; p < LIST_SIZE; p++) begin : g_mask
        for (genvar s = 0; s < LIST_SIZE; s++) begin : g_slot
            // R8
            masked_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !path_active[p]) |=>
                    (out_parent[s*PIDX_W +: PIDX_W] != PIDX_W'(p)
                     || met[s] == {METRIC_W{1'b1}}));
        end
    end

endmodule

bind list_path_selector lps_checker #(
    .LIST_SIZE (LIST_SIZE),
    .METRIC_W  (METRIC_W)
) i_chk (.*);

// File: tb/test_list_path_selector.sv
// Self-checking bench: behavioural selection model compared every clock.
module test_list_path_selector;

    localparam int L  = 4;
    localparam int W  = 13;
    localparam int NC = 2 * L;
    localparam int PW = 2;
    localparam int MAXM = (1 << W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [NC*W-1:0]   in_metrics = '0;
    logic [L-1:0]      path_active = '0;
    logic              out_valid;
    logic [L*PW-1:0]   out_parent;
    logic [L-1:0]      out_bit;
    logic [L*W-1:0]    out_metric;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int exp_par [L];
    int exp_bit [L];
    int exp_met [L];
    bit exp_valid;
    logic [NC*W-1:0] stim;

    always #4 clk = ~clk;

    list_path_selector #(.LIST_SIZE(L), .METRIC_W(W)) i_list_path_selector (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_metrics(in_metrics),
        .path_active(path_active), .out_valid(out_valid), .out_parent(out_parent),
        .out_bit(out_bit), .out_metric(out_metric)
    );

    // Behavioural reference: repeatedly pick the smallest untaken metric,
    // scanning candidates in ascending index so ties favour the lower index.
    task automatic model(input logic [NC*W-1:0] m, input logic [L-1:0] act);
        int met [NC];
        bit taken [NC];
        for (int c = 0; c < NC; c++) begin
            met[c] = act[c/2] ? int'(m[c*W +: W]) : MAXM;
            taken[c] = 0;
        end
        for (int s = 0; s < L; s++) begin
            int best = -1;
            for (int c = 0; c < NC; c++)
                if (!taken[c] && (best < 0 || met[c] < met[best])) best = c;
            taken[best] = 1;
            exp_par[s] = best / 2;
            exp_bit[s] = best % 2;
            exp_met[s] = met[best];
        end
    endtask

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, "out_valid", int'(out_valid), int'(exp_valid));
        for (int s = 0; s < L; s++) begin
            check(tag, $sformatf("slot%0d parent", s), int'(out_parent[s*PW +: PW]), exp_par[s]);
            check(tag, $sformatf("slot%0d bit", s), int'(out_bit[s]), exp_bit[s]);
            check(tag, $sformatf("slot%0d metric", s), int'(out_metric[s*W +: W]), exp_met[s]);
        end
    endtask

    // Drive one cycle, update the model at the edge, compare mid-cycle.
    task automatic step(input bit v, input logic [NC*W-1:0] m,
                        input logic [L-1:0] a, input string tag);
        in_valid = v; in_metrics = m; path_active = a;
        @(posedge clk);
        if (!rst_n) begin
            model('0, '1);
            exp_valid = 0;
        end else begin
            exp_valid = v;
            if (v) model(m, a);
        end
        #2;
        compare(tag);
    endtask

    task automatic put(input int c, input int val);
        stim[c*W +: W] = W'(val);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        rst_n = 0;
        for (int k = 0; k < 3; k++) step(1, '1, '1, "R1");
        rst_n = 1;

        // R8: only the initial path live
        stim = '0;
        for (int c = 0; c < NC; c++) put(c, 9 - c);
        step(1, stim, 4'b0001, "R8");
        step(1, stim, 4'b0100, "R8");

        // R3/R4: distinct metrics, all paths live
        for (int c = 0; c < NC; c++) put(c, (c * 37 + 11) % 101);
        step(1, stim, '1, "R4");
        put(5, 0); put(2, 1);
        step(1, stim, '1, "R3");

        // R6: full and partial ties
        for (int c = 0; c < NC; c++) put(c, 100);
        step(1, stim, '1, "R6");
        put(7, 50); put(3, 50); put(6, 20);
        step(1, stim, '1, "R6");

        // R5: strictly descending by index
        for (int c = 0; c < NC; c++) put(c, 1000 - 10 * c);
        step(1, stim, '1, "R5");

        // R9: idle cycles with changing inputs must not disturb outputs
        step(0, '0, 4'b0001, "R9");
        step(0, '1, '0, "R9");

        // R2: valid pulse followed by idle
        for (int c = 0; c < NC; c++) put(c, MAXM - c);
        step(1, stim, '1, "R2");
        step(0, stim, '1, "R2");

        // R7/R10: random metrics (small range to force ties) and masks
        for (int k = 0; k < 60; k++) begin
            for (int c = 0; c < NC; c++)
                put(c, (k % 3 == 0) ? int'($urandom_range(0, 7)) : int'($urandom_range(0, MAXM)));
            step($urandom_range(0, 3) != 0, stim, L'($urandom_range(1, 15)),
                 (k % 2 == 0) ? "R7" : "R10");
        end

        // R1: reset in mid-run
        rst_n = 0;
        step(1, stim, '1, "R1");
        step(0, stim, '1, "R1");
        rst_n = 1;
        step(0, stim, '1, "R9");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule